// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls an eight-pin general-purpose I/O port from a small synchronous register bus. Three byte-wide registers set each pin's behaviour. The output latch holds the value each pin should present. The input mode register chooses, per pin, between digital and analog operation. The drive mode register chooses, per pin, between push-pull and open-drain output. From these three registers the block produces four control vectors for the pads: driver enable, drive value, weak pull-up enable and digital receiver enable.

A byte read at the latch address does not return the stored latch. It returns the live pin levels, brought through a two-stage synchronizer. Any pin in analog mode reads as zero. Reads at the two mode-register addresses return the stored values unchanged.

Firmware can also change a single latch bit in one cycle, without a read-modify-write. A bit write carries a bit index and a bit value.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets the output latch to 0xFF, the input mode register to 0xFF (all pins digital), the drive mode register to 0x00 (all pins open-drain) and `rdata` to 0x00.
- R2: A byte write (`wr_en`=1) at address 0xF4 loads the input mode register, and one at 0xA7 loads the drive mode register. A read at either address returns the stored byte.
- R3: For a digital pin (input mode bit 1) whose latch bit is 0, `pad_oe`=1, `pad_out`=0 and `pad_pu`=0, in either drive mode.
- R4: For a digital pin with latch bit 1 and drive mode bit 1 (push-pull), `pad_oe`=1, `pad_out`=1 and `pad_pu`=1.
- R5: For a digital pin with latch bit 1 and drive mode bit 0 (open-drain), `pad_oe`=0, `pad_out`=0 and `pad_pu`=1, so the pin is released.
- R6: A pin whose input mode bit is 0 is analog. Its `pad_oe`, `pad_out`, `pad_pu` and `pad_rx_en` bits are all 0, whatever its latch and drive mode bits hold. A digital pin has `pad_rx_en`=1.
- R7: A read at address 0xB0 returns the synchronized pin level in each digital bit position and 0 in each analog bit position.
- R8: `rdata` takes new data on the clock edge that samples `rd_en`=1 and keeps its value while `rd_en`=0. A read at an unmapped address returns 0x00.
- R9: A bit write (`bit_wr_en`=1, `wr_en`=0, `addr`=0xB0) sets latch bit `bit_idx` (0 to 7) to `bit_val` in one cycle and leaves the other seven bits unchanged.
- R10: A bit write at any address other than 0xB0, and a byte write at an unmapped address, leave all three registers unchanged.
- R11: When `wr_en` and `bit_wr_en` are both 1 at address 0xB0, the byte write alone takes effect.
- R12: The level a pin input has at clock edge k is returned by a latch-address read whose `rd_en` is sampled at edge k+2 or later. A read whose `rd_en` is sampled at edge k or k+1 returns the previous level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| bit_wr_en | input | 1 | Single-bit latch write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Byte write data |
| bit_idx | input | 3 | Latch bit selected by a bit write |
| bit_val | input | 1 | Value stored by a bit write |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 8 | Pin levels seen at the pads |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| pad_rx_en | output | 8 | Per-pin digital receiver enable |

## Verification
The bench applies mixed configurations in which analog, open-drain and push-pull pins sit side by side. Each failure mode then shows up in a different bit position:
- A design that let analog mode fall through to the drive mode bit would enable a driver on an analog pin.
- A design that returned the latch on a port read would show latch bits where pin levels belong.

For bit writes, the bench clears one bit and then sets it again, to catch an index that hits the wrong bit or disturbs its neighbours. It also checks that a bit write at a wrong address, and a bit write alongside a byte write, change nothing extra.

It times a pin change against consecutive reads. A synchronizer that is one stage short, or one stage long, would return the new level a cycle early or a cycle late.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = $clog2(PORT_W);

    localparam logic [ADDR_W-1:0] DEF_LATCH_ADDR = 8'hB0;
    localparam logic [ADDR_W-1:0] DEF_INMODE_ADDR = 8'hF4;
    localparam logic [ADDR_W-1:0] DEF_DRVMODE_ADDR = 8'hA7;

    localparam logic [PORT_W-1:0] LATCH_RST = {PORT_W{1'b1}};
    localparam logic [PORT_W-1:0] INMODE_RST = {PORT_W{1'b1}};
    localparam logic [PORT_W-1:0] DRVMODE_RST = {PORT_W{1'b0}};

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_LATCH   = 2'd1,
        SEL_INMODE  = 2'd2,
        SEL_DRVMODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] in_mode;
        logic [PORT_W-1:0] drv_mode;
    } port_cfg_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] pu;
        logic [PORT_W-1:0] rx;
    } pad_ctl_t;

    function automatic reg_sel_e decode_addr(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] latch_a,
        input logic [ADDR_W-1:0] inmode_a,
        input logic [ADDR_W-1:0] drvmode_a
    );
        if (a == latch_a)        return SEL_LATCH;
        else if (a == inmode_a)  return SEL_INMODE;
        else if (a == drvmode_a) return SEL_DRVMODE;
        else                     return SEL_NONE;
    endfunction

    // Per-pin pad control: analog forces everything off, drive mode only
    // matters when the latch asks for a high level.
    function automatic logic [3:0] pin_ctl(
        input logic digital,
        input logic lat,
        input logic push_pull
    );
        logic oe;
        logic val;
        logic pu;
        oe  = digital & (~lat | push_pull);
        val = digital & lat & push_pull;
        pu  = digital & lat;
        return {oe, val, pu, digital};
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W,
    parameter logic [AW-1:0] LATCH_ADDR = DEF_LATCH_ADDR,
    parameter logic [AW-1:0] INMODE_ADDR = DEF_INMODE_ADDR,
    parameter logic [AW-1:0] DRVMODE_ADDR = DEF_DRVMODE_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          bit_wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output port_cfg_t     cfg
);

    reg_sel_e sel;
    logic     bit_hit;

    assign sel     = decode_addr(addr, LATCH_ADDR, INMODE_ADDR, DRVMODE_ADDR);
    assign bit_hit = bit_wr_en && !wr_en && (sel == SEL_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.latch    <= LATCH_RST;
            cfg.in_mode  <= INMODE_RST;
            cfg.drv_mode <= DRVMODE_RST;
        end else if (wr_en) begin
            case (sel)
                SEL_LATCH:   cfg.latch    <= wdata;
                SEL_INMODE:  cfg.in_mode  <= wdata;
                SEL_DRVMODE: cfg.drv_mode <= wdata;
                default: ;
            endcase
        end else if (bit_hit) begin
            cfg.latch[bit_idx] <= bit_val;
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (cfg.latch == LATCH_RST && cfg.in_mode == INMODE_RST
                 && cfg.drv_mode == DRVMODE_RST));

    // R9
    bit_wr_one_chk: assert property (@(posedge clk) disable iff (rst)
        bit_hit |=> ((((cfg.latch ^ $past(cfg.latch))
                      & ~({{(W-1){1'b0}}, 1'b1} << $past(bit_idx))) == '0)
                     && (cfg.latch[$past(bit_idx)] == $past(bit_val))));

    // R10
    bit_wr_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_wr_en && !wr_en && sel != SEL_LATCH) |=> $stable(cfg));

    // R11
    byte_over_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bit_wr_en && sel == SEL_LATCH) |=> (cfg.latch == $past(wdata)));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg,
    output pad_ctl_t  pads
);

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic [3:0] ctl;
        assign ctl = pin_ctl(cfg.in_mode[p], cfg.latch[p], cfg.drv_mode[p]);
        assign pads.oe[p]  = ctl[3];
        assign pads.out[p] = ctl[2];
        assign pads.pu[p]  = ctl[1];
        assign pads.rx[p]  = ctl[0];
    end

    // R6
    analog_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((pads.oe | pads.out | pads.pu | pads.rx) & ~cfg.in_mode) == '0);

    // R5
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pads.oe & cfg.latch & ~cfg.drv_mode) == '0);

    // R3
    pu_not_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pads.pu & pads.oe & ~pads.out) == '0);

    // R4
    pp_high_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg.in_mode & cfg.latch & cfg.drv_mode) & ~(pads.oe & pads.out)) == '0);

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W,
    parameter int SYNC_STAGES = 2,
    parameter logic [AW-1:0] LATCH_ADDR = DEF_LATCH_ADDR,
    parameter logic [AW-1:0] INMODE_ADDR = DEF_INMODE_ADDR,
    parameter logic [AW-1:0] DRVMODE_ADDR = DEF_DRVMODE_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          bit_wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_pu,
    output logic [W-1:0]  pad_rx_en
);

    port_cfg_t    cfg;
    pad_ctl_t     pads;
    logic [W-1:0] pin_sync;
    reg_sel_e     rd_sel;

    gpio_regfile #(
        .W(W), .AW(AW), .IW(IW),
        .LATCH_ADDR(LATCH_ADDR), .INMODE_ADDR(INMODE_ADDR),
        .DRVMODE_ADDR(DRVMODE_ADDR)
    ) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .bit_wr_en(bit_wr_en),
        .addr(addr), .wdata(wdata), .bit_idx(bit_idx), .bit_val(bit_val),
        .cfg(cfg)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
    );

    gpio_pad_ctrl #(.W(W)) i_pads (
        .clk(clk), .rst(rst), .cfg(cfg), .pads(pads)
    );

    assign pad_oe    = pads.oe;
    assign pad_out   = pads.out;
    assign pad_pu    = pads.pu;
    assign pad_rx_en = pads.rx;

    assign rd_sel = decode_addr(addr, LATCH_ADDR, INMODE_ADDR, DRVMODE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (rd_sel)
                SEL_LATCH:   rdata <= pin_sync & cfg.in_mode;
                SEL_INMODE:  rdata <= cfg.in_mode;
                SEL_DRVMODE: rdata <= cfg.drv_mode;
                default:     rdata <= '0;
            endcase
        end
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R7
    analog_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_LATCH) |=> ((rdata & ~$past(pads.rx)) == '0));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

    localparam logic [7:0] A_LATCH = 8'hB0;
    localparam logic [7:0] A_MODE  = 8'hF4;
    localparam logic [7:0] A_DRV   = 8'hA7;

    // {in_mode, drv_mode, latch, pin_in, exp_oe, exp_out, exp_pu, exp_rx, exp_rd}
    localparam int NVEC = 6;
    localparam logic [71:0] VEC [NVEC] = '{
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00},
        {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
        {8'hFF, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hA5},
        {8'h00, 8'hFF, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'hF0, 8'hCC, 8'hAA, 8'h3C, 8'hD0, 8'h80, 8'hA0, 8'hF0, 8'h30},
        {8'h5A, 8'h0F, 8'h33, 8'hFF, 8'h4A, 8'h02, 8'h12, 8'h5A, 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       bit_wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [2:0] bit_idx = 3'd0;
    logic       bit_val = 1'b0;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pad_pu;
    logic [7:0] pad_rx_en;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .bit_wr_en(bit_wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .bit_idx(bit_idx),
        .bit_val(bit_val), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .pad_rx_en(pad_rx_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic [2:0] idx, input logic v);
        @(negedge clk);
        bit_wr_en = 1'b1; addr = a; bit_idx = idx; bit_val = v;
        @(negedge clk);
        bit_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_pads(input string req, input logic [7:0] oe, input logic [7:0] val,
                              input logic [7:0] pu, input logic [7:0] rx);
        check({req, " oe"}, pad_oe, oe);
        check({req, " out"}, pad_out, val);
        check({req, " pu"}, pad_pu, pu);
        check({req, " rx"}, pad_rx_en, rx);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", rdata, 8'h00);
        check_pads("R1", 8'h00, 8'h00, 8'hFF, 8'hFF);
        rd(A_MODE, d);  check("R1 in_mode", d, 8'hFF);
        rd(A_DRV, d);   check("R1 drv_mode", d, 8'h00);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            wr_byte(A_MODE, VEC[v][71:64]);
            wr_byte(A_DRV, VEC[v][63:56]);
            wr_byte(A_LATCH, VEC[v][55:48]);
            @(negedge clk);
            pin_in = VEC[v][47:40];
            idle(4);
            check_pads($sformatf("R3/R4/R5/R6 vec%0d", v),
                       VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8]);
            rd(A_LATCH, d);
            check($sformatf("R7 vec%0d port read", v), d, VEC[v][7:0]);
            rd(A_MODE, d);
            check($sformatf("R2 vec%0d in_mode", v), d, VEC[v][71:64]);
            rd(A_DRV, d);
            check($sformatf("R2 vec%0d drv_mode", v), d, VEC[v][63:56]);
        end

        // R9: bit writes
        wr_byte(A_MODE, 8'hFF);
        wr_byte(A_DRV, 8'h00);
        wr_byte(A_LATCH, 8'hFF);
        wr_bit(A_LATCH, 3'd3, 1'b0);
        check("R9 clear bit3 oe", pad_oe, 8'h08);
        check("R9 clear bit3 pu", pad_pu, 8'hF7);
        wr_bit(A_LATCH, 3'd7, 1'b0);
        check("R9 clear bit7 pu", pad_pu, 8'h77);
        wr_bit(A_LATCH, 3'd3, 1'b1);
        check("R9 set bit3 pu", pad_pu, 8'h7F);
        wr_bit(A_LATCH, 3'd0, 1'b1);
        check("R9 set already-set bit0 pu", pad_pu, 8'h7F);

        // R10: bit write at wrong address, byte write at unmapped address
        wr_bit(A_MODE, 3'd1, 1'b0);
        check("R10 bit write off-address latch", pad_pu, 8'h7F);
        rd(A_MODE, d);
        check("R10 bit write off-address in_mode", d, 8'hFF);
        wr_byte(8'h55, 8'h00);
        check("R10 unmapped byte write latch", pad_pu, 8'h7F);
        rd(A_MODE, d);  check("R10 unmapped in_mode", d, 8'hFF);
        rd(A_DRV, d);   check("R10 unmapped drv_mode", d, 8'h00);

        // R11: byte write wins over bit write in the same cycle
        @(negedge clk);
        wr_en = 1'b1; bit_wr_en = 1'b1; addr = A_LATCH;
        wdata = 8'h00; bit_idx = 3'd0; bit_val = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bit_wr_en = 1'b0;
        check("R11 latch from byte only", pad_pu, 8'h00);
        check("R11 drivers low", pad_oe, 8'hFF);

        // R8: hold and unmapped read
        rd(8'h12, d);
        check("R8 unmapped read", d, 8'h00);
        rd(A_MODE, d);
        addr = A_DRV;
        idle(2);
        check("R8 rdata holds without rd_en", rdata, 8'hFF);

        // R12: synchronizer timing
        pin_in = 8'h00;
        idle(4);
        @(negedge clk);
        pin_in = 8'hFF; rd_en = 1'b1; addr = A_LATCH;
        @(negedge clk);
        check("R12 read at edge k", rdata, 8'h00);
        @(negedge clk);
        check("R12 read at edge k+1", rdata, 8'h00);
        @(negedge clk);
        check("R12 read at edge k+2", rdata, 8'hFF);
        rd_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule